// File: doc/BRIEF.md
# Iterative Signed Integer Divider

This block is a multi-cycle divide and modulus unit for a 64-bit processor core. A one-cycle start pulse hands it a dividend, a divisor and a set of mode bits. The mode bits select signed or unsigned arithmetic, a 64-bit or 32-bit operation, quotient or remainder, and an extended form in which the dividend is moved into the upper half of a double-width value. The unit captures the operands and the mode at acceptance. It makes operands positive in an extra cycle when that is needed, then runs a restoring shift-subtract loop that produces one quotient bit per clock. When the next eight quotient bits are provably zero, the loop takes all eight in one cycle.

Overflow is gathered while the work runs. One extra comparison ahead of the loop produces the quotient bit of weight 2^64, which catches division by zero and quotients that are too large. During the loop, any quotient one-bit that lands in the upper half is recorded for 32-bit operations. An output stage applies the sign, checks the representable range for the mode and formats the 32-bit cases. It then computes a condition word and writes everything through one output register. Invalid or overflowing operations return zero, with only the equal flag set.

Top module: `iter_divider`

## Requirements
- R1: An unsigned 64-bit operation returns floor(dividend/divisor) in quotient mode and dividend mod divisor in remainder mode. The condition word has bit 31 = result bit 63 (less), bit 30 = result nonzero with bit 63 clear (greater) and bit 29 = result zero (equal). All other bits are zero.
- R2: In a signed operation the quotient magnitude is |dividend|/|divisor|. The quotient is negative when exactly one operand is negative. The remainder carries the sign of the dividend.
- R3: A divisor of zero, or a quotient of 2^64 or more, gives a result of 0 and a condition word of 0x20000000. This applies in both quotient and remainder modes.
- R4: In signed quotient mode, a quotient outside the two's-complement range of the operation width (for example the most negative value divided by -1) gives result 0 and condition 0x20000000.
- R5: A 32-bit operation uses only bits 31:0 of each operand. Those bits are sign-extended in signed mode and zero-extended in unsigned mode. In quotient mode, a quotient that needs more than 32 bits gives result 0 and condition 0x20000000.
- R6: A 32-bit signed quotient has result bits 63:32 forced to zero, so the less flag is never set. A 32-bit signed remainder is sign-filled into bits 63:32. A 32-bit unsigned result is zero-filled.
- R7: In extended mode the dividend magnitude is multiplied by 2^64 for 64-bit operations, or by 2^32 for 32-bit operations, before dividing. A signed extended 64-bit divide therefore overflows whenever |dividend| >= |divisor|.
- R8: Reset clears all outputs and returns the unit to idle, abandoning any operation. The valid output is high for exactly one cycle per accepted operation. The register-write enable equals valid. The condition-write enable is valid ANDed with the condition request captured at start.
- R9: A start pulse that arrives while an operation is in progress is ignored. It produces no extra result and does not change the result in progress.
- R10: Valid rises at most 67 cycles after the accepting edge. For a non-extended operation whose dividend magnitude is below 256, valid rises at most 18 cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only when idle |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| sgn_i | input | 1 | 1 = signed operation |
| w32_i | input | 1 | 1 = 32-bit operation |
| rem_i | input | 1 | 1 = return remainder, 0 = quotient |
| ext_i | input | 1 | 1 = extended (upper-half) dividend |
| setc_i | input | 1 | Request a condition-word write |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_wr_reg_o | output | 1 | Register-write enable |
| res_wr_cond_o | output | 1 | Condition-write enable |
| res_data_o | output | 64 | Result data |
| res_cond_o | output | 32 | Condition word |

## Verification
The assertions assume that reset is held for at least one edge before the first operation. They also assume the mode bits matter only on the edge where start is accepted. The no-change check for a start during a busy period depends on the captured mode never being rewritten outside idle. The stimulus keeps one operation in flight, waits for its result before the next start, and breaks this rule only on purpose: to pulse start mid-operation and to assert reset in the middle of a divide.

// File: rtl/divu_pkg.sv
package divu_pkg;
  localparam int DW   = 64;
  localparam int HW   = DW / 2;
  localparam int SKIP = 8;
  localparam int CW   = 32;
  localparam int CNTW = $clog2(DW + 1);

  localparam logic [CNTW-1:0] CNT_END      = CNTW'(DW);
  localparam logic [CNTW-1:0] CNT_HALF     = CNTW'(HW);
  localparam logic [CNTW-1:0] CNT_SKIP     = CNTW'(SKIP);
  localparam logic [CNTW-1:0] CNT_ONE      = CNTW'(1);
  localparam logic [CNTW-1:0] CNT_SKIP_LIM = CNTW'(DW - SKIP);
  localparam logic [CW-1:0]   COND_EQ      = CW'(1) << (CW - 3);

  typedef logic [DW-1:0] word_t;

  typedef enum logic [2:0] {ST_IDLE, ST_NEG, ST_OVCHK, ST_ITER, ST_FINISH} st_e;

  typedef struct packed {
    logic sgn;
    logic w32;
    logic rem;
    logic ext;
    logic setc;
  } mode_t;

  // Bring a raw operand to full width according to the mode.
  function automatic word_t widen(input word_t v, input logic sgn, input logic w32);
    if (!w32) return v;
    if (sgn) return {{HW{v[HW-1]}}, v[HW-1:0]};
    return {{HW{1'b0}}, v[HW-1:0]};
  endfunction

  function automatic word_t magnitude(input word_t v, input logic neg);
    return neg ? (~v + word_t'(1)) : v;
  endfunction

  // Place the dividend magnitude into the {partial remainder, dividend} pair.
  function automatic logic [2*DW-1:0] load_work(input word_t mag, input logic ext, input logic w32);
    if (!ext) return {word_t'(0), mag};
    if (w32) return {word_t'(0), mag << HW};
    return {mag, word_t'(0)};
  endfunction

  function automatic logic [CW-1:0] cond_of(input word_t d);
    logic [CW-1:0] c;
    c = '0;
    c[CW-1] = d[DW-1];
    c[CW-2] = !d[DW-1] && (d != '0);
    c[CW-3] = (d == '0);
    return c;
  endfunction
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import divu_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  logic  sgn_i,
  input  logic  w32_i,
  output word_t a_o,
  output word_t b_o,
  output logic  neg_a_o,
  output logic  neg_b_o
);
  assign a_o     = widen(a_i, sgn_i, w32_i);
  assign b_o     = widen(b_i, sgn_i, w32_i);
  assign neg_a_o = sgn_i && a_o[DW-1];
  assign neg_b_o = sgn_i && b_o[DW-1];
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import divu_pkg::*;
(
  input  word_t           prem_i,
  input  word_t           dq_i,
  input  word_t           dvs_i,
  input  logic [CNTW-1:0] cnt_i,
  output word_t           prem_o,
  output word_t           dq_o,
  output logic [CNTW-1:0] cnt_o,
  output logic            qbit_o,
  output logic            skip_o
);
  logic [DW:0] trial;
  logic [DW:0] diff;
  logic        ge;

  assign skip_o = (prem_i == '0) && (dq_i[DW-1 -: SKIP] == '0) && (cnt_i < CNT_SKIP_LIM);
  assign trial  = {prem_i, dq_i[DW-1]};
  assign ge     = trial >= {1'b0, dvs_i};
  assign diff   = trial - {1'b0, dvs_i};

  always_comb begin
    if (skip_o) begin
      prem_o = prem_i;
      dq_o   = dq_i << SKIP;
      cnt_o  = cnt_i + CNT_SKIP;
      qbit_o = 1'b0;
    end else begin
      prem_o = ge ? diff[DW-1:0] : trial[DW-1:0];
      dq_o   = {dq_i[DW-2:0], ge};
      cnt_o  = cnt_i + CNT_ONE;
      qbit_o = ge;
    end
  end
endmodule

// File: rtl/div_out_format.sv
module div_out_format
  import divu_pkg::*;
(
  input  word_t          quo_i,
  input  word_t          rmd_i,
  input  mode_t          md_i,
  input  logic           neg_a_i,
  input  logic           neg_b_i,
  input  logic           ovf_i,
  input  logic           hi_i,
  output word_t          data_o,
  output logic [CW-1:0]  cond_o,
  output logic           invalid_o
);
  logic  neg_q;
  word_t lim;
  word_t res;
  logic  rng_bad;

  assign neg_q     = neg_a_i ^ neg_b_i;
  assign lim       = word_t'(1) << (md_i.w32 ? HW - 1 : DW - 1);
  assign rng_bad   = md_i.sgn && (neg_q ? (quo_i > lim) : (quo_i >= lim));
  assign invalid_o = ovf_i || (!md_i.rem && ((md_i.w32 && hi_i) || rng_bad));
  assign res       = md_i.rem ? magnitude(rmd_i, neg_a_i) : magnitude(quo_i, neg_q);

  always_comb begin
    if (invalid_o)
      data_o = '0;
    else if (md_i.w32 && md_i.sgn && md_i.rem)
      data_o = {{HW{res[HW-1]}}, res[HW-1:0]};
    else if (md_i.w32)
      data_o = {{HW{1'b0}}, res[HW-1:0]};
    else
      data_o = res;
  end

  assign cond_o = cond_of(data_o);
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import divu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [63:0]   dividend_i,
  input  logic [63:0]   divisor_i,
  input  logic          sgn_i,
  input  logic          w32_i,
  input  logic          rem_i,
  input  logic          ext_i,
  input  logic          setc_i,
  output logic          res_valid_o,
  output logic          res_wr_reg_o,
  output logic          res_wr_cond_o,
  output logic [63:0]   res_data_o,
  output logic [31:0]   res_cond_o
);
  st_e             st;
  mode_t           md;
  logic            neg_a, neg_b;
  word_t           opa, opb;
  word_t           prem, dq;
  logic [CNTW-1:0] cnt;
  logic            ovf_big, hi32;

  // operand preparation
  word_t ext_a, ext_b;
  logic  pre_na, pre_nb;
  div_operand_prep u_prep (
    .a_i(dividend_i), .b_i(divisor_i), .sgn_i(sgn_i), .w32_i(w32_i),
    .a_o(ext_a), .b_o(ext_b), .neg_a_o(pre_na), .neg_b_o(pre_nb)
  );

  // iteration step
  word_t           step_prem, step_dq;
  logic [CNTW-1:0] step_cnt;
  logic            step_qbit, step_skip;
  div_step_unit u_step (
    .prem_i(prem), .dq_i(dq), .dvs_i(opb), .cnt_i(cnt),
    .prem_o(step_prem), .dq_o(step_dq), .cnt_o(step_cnt),
    .qbit_o(step_qbit), .skip_o(step_skip)
  );

  // output formatting
  word_t         fmt_data;
  logic [CW-1:0] fmt_cond;
  logic          fmt_invalid;
  div_out_format u_fmt (
    .quo_i(dq), .rmd_i(prem), .md_i(md), .neg_a_i(neg_a), .neg_b_i(neg_b),
    .ovf_i(ovf_big), .hi_i(hi32),
    .data_o(fmt_data), .cond_o(fmt_cond), .invalid_o(fmt_invalid)
  );

  // named internal events
  logic busy_w, accept_w, iter_w, finish_w, ovf_hit_w, skip_w;
  assign busy_w    = (st != ST_IDLE);
  assign accept_w  = (st == ST_IDLE) && start;
  assign iter_w    = (st == ST_ITER);
  assign finish_w  = (st == ST_FINISH);
  assign ovf_hit_w = (st == ST_OVCHK) && (prem >= opb);
  assign skip_w    = iter_w && step_skip;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      md            <= '0;
      neg_a         <= 1'b0;
      neg_b         <= 1'b0;
      opa           <= '0;
      opb           <= '0;
      prem          <= '0;
      dq            <= '0;
      cnt           <= '0;
      ovf_big       <= 1'b0;
      hi32          <= 1'b0;
      res_valid_o   <= 1'b0;
      res_wr_reg_o  <= 1'b0;
      res_wr_cond_o <= 1'b0;
      res_data_o    <= '0;
      res_cond_o    <= '0;
    end else begin
      res_valid_o   <= finish_w;
      res_wr_reg_o  <= finish_w;
      res_wr_cond_o <= finish_w && md.setc;
      if (finish_w) begin
        res_data_o <= fmt_data;
        res_cond_o <= fmt_cond;
      end
      case (st)
        ST_IDLE: begin
          if (start) begin
            md      <= '{sgn: sgn_i, w32: w32_i, rem: rem_i, ext: ext_i, setc: setc_i};
            neg_a   <= pre_na;
            neg_b   <= pre_nb;
            opa     <= ext_a;
            opb     <= ext_b;
            cnt     <= '0;
            ovf_big <= 1'b0;
            hi32    <= 1'b0;
            if (pre_na || pre_nb) begin
              st <= ST_NEG;
            end else begin
              {prem, dq} <= load_work(ext_a, ext_i, w32_i);
              st         <= ST_OVCHK;
            end
          end
        end
        ST_NEG: begin
          opb        <= magnitude(opb, neg_b);
          {prem, dq} <= load_work(magnitude(opa, neg_a), md.ext, md.w32);
          st         <= ST_OVCHK;
        end
        ST_OVCHK: begin
          if (ovf_hit_w) begin
            ovf_big <= 1'b1;
            st      <= ST_FINISH;
          end else begin
            st <= ST_ITER;
          end
        end
        ST_ITER: begin
          prem <= step_prem;
          dq   <= step_dq;
          cnt  <= step_cnt;
          if (step_qbit && (cnt < CNT_HALF)) hi32 <= 1'b1;
          if (step_cnt == CNT_END) st <= ST_FINISH;
        end
        ST_FINISH: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divu_checker.sv
module divu_checker
  import divu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            accept,
  input logic            finish,
  input logic            invalid,
  input logic            iter,
  input logic [CNTW-1:0] cnt,
  input mode_t           md,
  input logic            out_valid,
  input logic            out_wr_reg,
  input logic            out_wr_cond,
  input logic [63:0]     out_data,
  input logic [31:0]     out_cond
);
  logic [7:0] lat;
  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else if (accept) lat <= 8'd1;
    else if (lat != 8'd0 && lat != 8'hFF) lat <= lat + 8'd1;
  end

  assert_reset_R8: assert property (@(posedge clk) rst |=> !out_valid);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  assert_wr_reg_R8: assert property (@(posedge clk) disable iff (rst) out_wr_reg == out_valid);
  assert_wr_cond_R8: assert property (@(posedge clk) disable iff (rst) out_wr_cond |-> out_valid);
  assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (rst)
    finish && invalid |=> out_valid && out_data == 64'd0 && out_cond == COND_EQ);
  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(md));
  assert_w32_sdiv_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && md.w32 && md.sgn && !md.rem |-> out_data[63:32] == 32'd0 && !out_cond[31]);
  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lat != 8'd0 && lat <= 8'd68);
  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    iter |-> cnt < CNT_END);
endmodule

bind iter_divider divu_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_w), .accept(accept_w),
  .finish(finish_w), .invalid(fmt_invalid), .iter(iter_w), .cnt(cnt), .md(md),
  .out_valid(res_valid_o), .out_wr_reg(res_wr_reg_o), .out_wr_cond(res_wr_cond_o),
  .out_data(res_data_o), .out_cond(res_cond_o)
);

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  logic        clk = 1'b0;
  logic        rst, start, sgn, w32, rem, ext, setc;
  logic [63:0] a, b;
  logic        vld, wrr, wrc;
  logic [63:0] dout;
  logic [31:0] cout;

  iter_divider dut (
    .clk(clk), .rst(rst), .start(start), .dividend_i(a), .divisor_i(b),
    .sgn_i(sgn), .w32_i(w32), .rem_i(rem), .ext_i(ext), .setc_i(setc),
    .res_valid_o(vld), .res_wr_reg_o(wrr), .res_wr_cond_o(wrc),
    .res_data_o(dout), .res_cond_o(cout)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, stray = 0;
  bit prev_v = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] q_data[$];
  logic [31:0] q_cond[$];
  bit          q_wrc[$], q_fast[$];
  int          q_t0[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] x, y, input bit s, w, r, e,
                                output logic [63:0] d, output logic [31:0] c);
    logic [63:0]  ea, eb, ma, mb, v;
    logic [127:0] dd, qq, rr, lim;
    bit na, nb, bad;
    ea = w ? (s ? {{32{x[31]}}, x[31:0]} : {32'h0, x[31:0]}) : x;
    eb = w ? (s ? {{32{y[31]}}, y[31:0]} : {32'h0, y[31:0]}) : y;
    na = s && ea[63];
    nb = s && eb[63];
    ma = na ? (~ea + 64'd1) : ea;
    mb = nb ? (~eb + 64'd1) : eb;
    dd = {64'h0, ma};
    if (e) dd = w ? (dd << 32) : (dd << 64);
    bad = 1'b0;
    qq = '0;
    rr = '0;
    if (mb == 64'd0 || dd[127:64] >= mb) bad = 1'b1;
    else begin
      qq = dd / {64'h0, mb};
      rr = dd % {64'h0, mb};
      if (!r) begin
        if (w && qq[127:32] != '0) bad = 1'b1;
        lim = 128'd1 << (w ? 31 : 63);
        if (s && ((na ^ nb) ? (qq > lim) : (qq >= lim))) bad = 1'b1;
      end
    end
    if (bad) d = '0;
    else begin
      if (r) v = na ? (~rr[63:0] + 64'd1) : rr[63:0];
      else   v = (na ^ nb) ? (~qq[63:0] + 64'd1) : qq[63:0];
      if (w) d = (s && r && v[31]) ? {32'hFFFF_FFFF, v[31:0]} : {32'h0, v[31:0]};
      else   d = v;
    end
    c = {d[63], !d[63] && (d != 64'd0), d == 64'd0, 29'd0};
  endfunction

  task automatic issue(input logic [63:0] x, y, input bit s, w, r, e, sc,
                       input string tag, input bit fast, input bit hold);
    logic [63:0] ed;
    logic [31:0] ec;
    model(x, y, s, w, r, e, ed, ec);
    @(negedge clk);
    q_data.push_back(ed); q_cond.push_back(ec); q_wrc.push_back(sc);
    q_tag.push_back(tag); q_fast.push_back(fast); q_t0.push_back(cyc + 1);
    a = x; b = y; sgn = s; w32 = w; rem = r; ext = e; setc = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (hold) while (q_data.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (vld && prev_v) chk(1'b0, "R8", "valid longer than one cycle", 64'd1, 64'd0);
      if (vld) begin
        if (q_data.size() == 0) begin
          stray++;
          chk(1'b0, "R9", "result with no accepted start", dout, 64'd0);
        end else begin
          logic [63:0] ed;
          logic [31:0] ec;
          bit ew, ef;
          int t0;
          string tg;
          ed = q_data.pop_front(); ec = q_cond.pop_front(); ew = q_wrc.pop_front();
          ef = q_fast.pop_front(); t0 = q_t0.pop_front(); tg = q_tag.pop_front();
          chk(dout === ed, tg, "data", dout, ed);
          chk(cout === ec, tg, "cond", {32'h0, cout}, {32'h0, ec});
          chk(wrr === 1'b1, "R8", "reg write enable", {63'h0, wrr}, 64'd1);
          chk(wrc === ew, "R8", "cond write enable", {63'h0, wrc}, {63'h0, ew});
          if (ef) chk(cyc - t0 <= 18, "R10", "fast latency", 64'(cyc - t0), 64'd18);
          else    chk(cyc - t0 <= 67, "R10", "latency", 64'(cyc - t0), 64'd67);
        end
      end else begin
        if (wrr || wrc) chk(1'b0, "R8", "write enable without valid", {62'h0, wrr, wrc}, 64'd0);
      end
      prev_v = vld;
    end else prev_v = 1'b0;
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  function automatic logic [63:0] xs(input logic [63:0] s);
    logic [63:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 7);
    return t ^ (t << 17);
  endfunction

  initial begin
    logic [63:0] seed;
    rst = 1'b1; start = 1'b0; a = '0; b = '0;
    sgn = 0; w32 = 0; rem = 0; ext = 0; setc = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(vld == 1'b0 && wrr == 1'b0 && wrc == 1'b0, "R8", "reset strobes", {61'h0, vld, wrr, wrc}, 64'd0);
    chk(dout == 64'd0 && cout == 32'd0, "R8", "reset data", dout, 64'd0);

    // R1 unsigned 64-bit
    issue(64'd100, 64'd7, 0, 0, 0, 0, 1, "R1", 1, 1);
    issue(64'd100, 64'd7, 0, 0, 1, 0, 0, "R1", 1, 1);
    issue(64'd0, 64'd5, 0, 0, 0, 0, 1, "R1", 1, 1);
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, 1, "R1", 0, 1);
    // R2 signed
    issue(-64'sd100, 64'd7, 1, 0, 0, 0, 1, "R2", 0, 1);
    issue(-64'sd100, 64'd7, 1, 0, 1, 0, 1, "R2", 0, 1);
    issue(64'd100, -64'sd7, 1, 0, 0, 0, 1, "R2", 0, 1);
    issue(64'd100, -64'sd7, 1, 0, 1, 0, 0, "R2", 0, 1);
    issue(-64'sd100, -64'sd7, 1, 0, 0, 0, 1, "R2", 0, 1);
    // R3 divide by zero and big quotient
    issue(64'd55, 64'd0, 0, 0, 0, 0, 1, "R3", 0, 1);
    issue(-64'sd55, 64'd0, 1, 0, 1, 0, 1, "R3", 0, 1);
    issue(64'd1, 64'd1, 0, 0, 0, 1, 1, "R3", 0, 1);
    // R4 signed range
    issue(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, 0, 1, "R4", 0, 1);
    issue(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, 1, "R4", 0, 1);
    issue(64'h8000_0000_0000_0000, 64'd1, 1, 0, 0, 0, 1, "R4", 0, 1);
    // R5 32-bit operand handling and overflow
    issue(64'hDEAD_BEEF_0000_0064, 64'h1234_0000_0000_0007, 0, 1, 0, 0, 1, "R5", 1, 1);
    issue(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1, 1, 0, 0, 1, "R5", 0, 1);
    issue(64'h0000_0000_FFFF_FFFF, 64'd2, 0, 1, 0, 0, 1, "R5", 0, 1);
    // R6 32-bit signed formatting
    issue(64'h0000_0000_FFFF_FF9C, 64'd7, 1, 1, 0, 0, 1, "R6", 0, 1);
    issue(64'h0000_0000_FFFF_FF9C, 64'd7, 1, 1, 1, 0, 1, "R6", 0, 1);
    issue(64'h0000_0000_0000_0064, 64'h0000_0000_FFFF_FFF9, 1, 1, 1, 0, 1, "R6", 0, 1);
    // R7 extended mode
    issue(64'd1, 64'd3, 0, 0, 0, 1, 1, "R7", 0, 1);
    issue(64'd1, -64'sd3, 1, 0, 0, 1, 1, "R7", 0, 1);
    issue(64'd3, -64'sd3, 1, 0, 0, 1, 1, "R7", 0, 1);
    issue(64'd1, 64'd3, 0, 1, 0, 1, 1, "R7", 0, 1);
    issue(64'd7, 64'd3, 0, 1, 0, 1, 1, "R7", 0, 1);

    // R9 start while busy is ignored
    issue(64'd1000, 64'd9, 0, 0, 0, 0, 1, "R9", 0, 0);
    repeat (4) @(negedge clk);
    a = 64'd77; b = 64'd0; sgn = 1; rem = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (q_data.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
    chk(stray == 0, "R9", "extra results", 64'(stray), 64'd0);

    // R8 reset abandons an operation
    issue(64'd123456, 64'd10, 0, 0, 0, 0, 1, "R8", 0, 0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    q_data.delete(); q_cond.delete(); q_wrc.delete();
    q_fast.delete(); q_t0.delete(); q_tag.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (80) @(negedge clk);
    chk(stray == 0, "R8", "result after reset", 64'(stray), 64'd0);
    issue(64'd99, 64'd10, 0, 0, 1, 0, 0, "R8", 1, 1);

    // mixed patterns across all modes
    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] x, y, m;
      seed = xs(seed); x = seed >> seed[5:0];
      seed = xs(seed); y = seed >> seed[5:0];
      seed = xs(seed); m = seed;
      if (m[9:8] == 2'b00) y = y & 64'hFF;
      issue(x, y, m[0], m[1], m[2], m[3] & m[4], m[5], "R1/R2 mix", 0, 1);
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule